// File: doc/BRIEF.md
# Halt/Idle Power-Save Controller

This controller sits beside a processor core and puts it into one of two sleep states on a software request. In the deep sleep state (HALT) the core clock is gated off and both the core and its timer are stopped. In the light sleep state (IDLE) the clock and one timer keep running, but the core itself is held. Neither state clears anything: the controller never touches RAM, registers or I/O. It only withholds clocks and enables.

Software issues a request as a one-cycle strobe that carries a two-bit mode code. Deep sleep is guarded by an enable bit that can be written only once after each reset, so a stray write cannot arm or disarm it later. The core leaves either sleep state when reset is asserted, which reinitialises everything. It also leaves on a rising edge of the non-maskable interrupt line. In that case the controller returns the core to running and hands it a one-cycle interrupt request, so that execution resumes through the interrupt vector without reinitialisation.

The stop-clock output is active low and is registered on the falling edge of the free-running clock. The gated core clock therefore never shows a truncated pulse.

Top module: `pwrsave_ctrl`

## Requirements
- R1: After reset the controller is running: core_en=1, timer_en=1, halt_o=0, idle_o=0, clk_stop_n=1, nmi_irq=0, and the deep-sleep enable halt_en_o=0.
- R2: While running, a strobe with req_mode=2'b01 enters IDLE at that clock edge: idle_o=1, core_en=0, timer_en=1.
- R3: While running with halt_en_o=1, a strobe with req_mode=2'b10 enters HALT at that edge: halt_o=1, core_en=0, timer_en=0.
- R4: A strobe with req_mode=2'b10 while halt_en_o=0 is ignored, and the core keeps running.
- R5: Strobes carrying req_mode=2'b00 or 2'b11 have no effect.
- R6: While in IDLE or HALT, further request strobes are ignored.
- R7: A rising edge on nmi while in IDLE or HALT returns the controller to running at the edge where nmi is first sampled high, and nmi_irq is high for exactly that one following cycle.
- R8: A rising edge on nmi while running changes nothing and gives no nmi_irq pulse.
- R9: The first hen_wr after reset loads hen_wdata into halt_en_o. Every later write is ignored until the next reset.
- R10: Reset from any state returns the controller to R1, and it reopens the enable register for one more write.
- R11: clk_stop_n goes low after the falling clock edge that follows HALT entry, and it goes high again after the falling edge that follows the exit. core_clk follows clk while clk_stop_n is high and stays low while clk_stop_n is low.
- R12: A deep-sleep request in the same cycle as the first enable write is judged against the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_stb | input | 1 | One-cycle sleep request strobe |
| req_mode | input | 2 | Requested mode: 01 light sleep, 10 deep sleep, others none |
| hen_wr | input | 1 | Write strobe for the deep-sleep enable |
| hen_wdata | input | 1 | Value written to the deep-sleep enable |
| nmi | input | 1 | Non-maskable interrupt, acts on its rising edge |
| halt_en_o | output | 1 | Current deep-sleep enable value |
| halt_o | output | 1 | High while in deep sleep |
| idle_o | output | 1 | High while in light sleep |
| core_en | output | 1 | Core run enable |
| timer_en | output | 1 | Timer run enable |
| clk_stop_n | output | 1 | Active-low stop-clock, updated on falling edges |
| core_clk | output | 1 | Gated core clock |
| nmi_irq | output | 1 | One-cycle wake interrupt request |

## Verification
The assertions check these properties on every cycle: the enable pattern of each sleep state, that deep sleep is never entered while disabled, that the stop-clock output agrees with the HALT status at each rising edge, that the wake pulse lasts a single cycle and comes only right after a sleep state, and that the enable register stays frozen after its first write. Other behaviour appears only in the bench's scenarios: which request codes have no effect, that requests are ignored while asleep, that an NMI does nothing while running, that reset reopens the enable register, the same-cycle race between a write and a request, and the actual suppression of core clock edges.

// File: rtl/pwrsave_pkg.sv
package pwrsave_pkg;
  localparam int MODE_W = 2;
  typedef logic [MODE_W-1:0] mode_code_t;
  localparam mode_code_t CODE_IDLE = 2'b01;
  localparam mode_code_t CODE_HALT = 2'b10;
  typedef enum logic [1:0] {PS_RUN = 2'd0, PS_IDLE = 2'd1, PS_HALT = 2'd2} ps_state_e;
endpackage

// File: rtl/ps_halt_guard.sv
// Write-once deep-sleep enable; the lock is cleared only by reset.
module ps_halt_guard #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  output logic en
);
  logic locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= RST_VAL;
      locked <= 1'b0;
    end else if (wr && !locked) begin
      en     <= wdata;
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/ps_mode_fsm.sv
// Sleep state machine with NMI edge wake and one-cycle wake interrupt.
module ps_mode_fsm
  import pwrsave_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_stb,
  input  mode_code_t req_mode,
  input  logic       halt_en,
  input  logic       nmi,
  output ps_state_e  state,
  output logic       wake_irq
);
  logic      nmi_q;
  logic      nmi_rise;
  ps_state_e state_nx;

  assign nmi_rise = nmi && !nmi_q;

  always_comb begin
    state_nx = state;
    unique case (state)
      PS_RUN: begin
        if (req_stb && req_mode == CODE_IDLE) state_nx = PS_IDLE;
        else if (req_stb && req_mode == CODE_HALT && halt_en) state_nx = PS_HALT;
      end
      PS_IDLE, PS_HALT: if (nmi_rise) state_nx = PS_RUN;
      default: state_nx = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_RUN;
      nmi_q    <= 1'b0;
      wake_irq <= 1'b0;
    end else begin
      state    <= state_nx;
      nmi_q    <= nmi;
      wake_irq <= (state != PS_RUN) && nmi_rise;
    end
  end
endmodule

// File: rtl/ps_clk_gate.sv
// Stop-clock register on the falling edge so the gated clock never glitches.
module ps_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  output logic stop_n,
  output logic gclk
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) stop_n <= 1'b1;
    else        stop_n <= !stop_req;
  end

  assign gclk = clk & stop_n;
endmodule

// File: rtl/pwrsave_ctrl.sv
module pwrsave_ctrl
  import pwrsave_pkg::*;
#(
  parameter logic HALT_EN_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_stb,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              hen_wr,
  input  logic              hen_wdata,
  input  logic              nmi,
  output logic              halt_en_o,
  output logic              halt_o,
  output logic              idle_o,
  output logic              core_en,
  output logic              timer_en,
  output logic              clk_stop_n,
  output logic              core_clk,
  output logic              nmi_irq
);
  ps_state_e state;

  ps_halt_guard #(.RST_VAL(HALT_EN_RST)) u_guard (
    .clk(clk), .rst_n(rst_n), .wr(hen_wr), .wdata(hen_wdata), .en(halt_en_o)
  );

  ps_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_mode(req_mode),
    .halt_en(halt_en_o), .nmi(nmi), .state(state), .wake_irq(nmi_irq)
  );

  ps_clk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .stop_req(state == PS_HALT),
    .stop_n(clk_stop_n), .gclk(core_clk)
  );

  assign halt_o   = (state == PS_HALT);
  assign idle_o   = (state == PS_IDLE);
  assign core_en  = (state == PS_RUN);
  assign timer_en = (state != PS_HALT);
endmodule

// File: rtl/pwrsave_ctrl_chk.sv
module pwrsave_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_stb,
  input logic [1:0] req_mode,
  input logic       hen_wr,
  input logic       halt_en_o,
  input logic       halt_o,
  input logic       idle_o,
  input logic       core_en,
  input logic       timer_en,
  input logic       clk_stop_n,
  input logic       nmi_irq
);
  logic wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_seen <= 1'b0;
    else if (hen_wr) wr_seen <= 1'b1;
  end

  // R3
  halt_stops_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (!core_en && !timer_en && !idle_o));

  // R2
  idle_keeps_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (timer_en && !core_en));

  // R4
  halt_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_stb && req_mode == 2'b10 && !halt_en_o && core_en) |=> !halt_o);

  // R7
  wake_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_irq |-> (core_en && $past(halt_o || idle_o)));

  // R7
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_irq |=> !nmi_irq);

  // R9
  write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_seen && hen_wr) |=> $stable(halt_en_o));

  // R11
  stop_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop_n == !halt_o);
endmodule

bind pwrsave_ctrl pwrsave_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_mode(req_mode),
  .hen_wr(hen_wr), .halt_en_o(halt_en_o), .halt_o(halt_o), .idle_o(idle_o),
  .core_en(core_en), .timer_en(timer_en), .clk_stop_n(clk_stop_n),
  .nmi_irq(nmi_irq)
);

// File: tb/test_pwrsave_ctrl.sv
`timescale 1ns/1ps
module test_pwrsave_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_stb = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic hen_wr = 1'b0;
  logic hen_wdata = 1'b0;
  logic nmi = 1'b0;
  logic halt_en_o, halt_o, idle_o, core_en, timer_en, clk_stop_n, core_clk, nmi_irq;

  int checks = 0;
  int failures = 0;
  int gclk_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge core_clk) gclk_cnt++;

  pwrsave_ctrl i_pwrsave_ctrl (
    .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_mode(req_mode),
    .hen_wr(hen_wr), .hen_wdata(hen_wdata), .nmi(nmi), .halt_en_o(halt_en_o),
    .halt_o(halt_o), .idle_o(idle_o), .core_en(core_en), .timer_en(timer_en),
    .clk_stop_n(clk_stop_n), .core_clk(core_clk), .nmi_irq(nmi_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_stb = 1'b0; hen_wr = 1'b0; nmi = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic write_en(input logic v);
    hen_wr = 1'b1; hen_wdata = v;
    tick();
    hen_wr = 1'b0;
  endtask

  task automatic request(input logic [1:0] m);
    req_stb = 1'b1; req_mode = m;
    tick();
    req_stb = 1'b0;
  endtask

  // state code: 0 run, 1 idle, 2 halt
  task automatic chk_state(input string req, input int exp);
    chk({req, " halt_o"}, int'(halt_o), int'(exp == 2));
    chk({req, " idle_o"}, int'(idle_o), int'(exp == 1));
    chk({req, " core_en"}, int'(core_en), int'(exp == 0));
    chk({req, " timer_en"}, int'(timer_en), int'(exp != 2));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk_state("R1", 0);
    chk("R1 clk_stop_n", int'(clk_stop_n), 1);
    chk("R1 nmi_irq", int'(nmi_irq), 0);
    chk("R1 halt_en_o", int'(halt_en_o), 0);

    // Sweep: enable value x request code, then wake by NMI
    for (int en = 0; en < 2; en++) begin
      for (int code = 0; code < 4; code++) begin
        int exp_st;
        int c0;
        do_reset();
        write_en(en[0]);
        chk("R9 first write", int'(halt_en_o), en);
        exp_st = (code == 1) ? 1 : ((code == 2 && en == 1) ? 2 : 0);
        request(code[1:0]);
        // R2 R3 R4 R5
        chk_state($sformatf("R2/R3 R4 R5 en=%0d code=%0d", en, code), exp_st);
        // R6: another strobe while asleep (or harmless one while running)
        request((code == 1) ? 2'b10 : 2'b01);
        if (exp_st != 0) chk_state("R6 asleep ignores request", exp_st);
        else begin
          exp_st = 1;
          chk_state("R2 idle after run", 1);
        end
        // R11 stop clock after falling edge
        @(negedge clk); #1;
        chk("R11 clk_stop_n", int'(clk_stop_n), int'(exp_st != 2));
        @(posedge clk); #2;
        c0 = gclk_cnt;
        repeat (4) tick();
        chk("R11 core_clk edges", gclk_cnt - c0, (exp_st == 2) ? 0 : 4);
        // R7 wake on NMI edge
        nmi = 1'b1;
        tick();
        chk_state("R7 wake", 0);
        chk("R7 nmi_irq pulse", int'(nmi_irq), 1);
        tick();
        chk("R7 nmi_irq single", int'(nmi_irq), 0);
        @(negedge clk); #1;
        chk("R11 clk_stop_n released", int'(clk_stop_n), 1);
        @(posedge clk); #2;
        // R8 NMI while running
        nmi = 1'b0; tick();
        nmi = 1'b1; tick();
        chk("R8 nmi_irq in run", int'(nmi_irq), 0);
        chk_state("R8 stays run", 0);
        tick();
        chk("R8 nmi_irq in run later", int'(nmi_irq), 0);
        nmi = 1'b0;
      end
    end

    // R9 later writes ignored
    do_reset();
    write_en(1'b1);
    write_en(1'b0);
    chk("R9 second write ignored", int'(halt_en_o), 1);
    write_en(1'b0);
    chk("R9 third write ignored", int'(halt_en_o), 1);
    request(2'b10);
    chk_state("R9 halt allowed", 2);

    // R10 reset from HALT reopens the register
    do_reset();
    chk_state("R10 run after reset", 0);
    chk("R10 enable cleared", int'(halt_en_o), 0);
    write_en(1'b1);
    chk("R10 write accepted again", int'(halt_en_o), 1);
    request(2'b01);
    chk_state("R10 idle", 1);
    do_reset();
    chk_state("R10 reset from idle", 0);
    chk("R10 clk_stop_n", int'(clk_stop_n), 1);

    // R12 write and request in the same cycle
    do_reset();
    hen_wr = 1'b1; hen_wdata = 1'b1; req_stb = 1'b1; req_mode = 2'b10;
    tick();
    hen_wr = 1'b0; req_stb = 1'b0;
    chk_state("R12 old enable used", 0);
    chk("R12 enable now set", int'(halt_en_o), 1);
    request(2'b10);
    chk_state("R12 later halt", 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule